// File: doc/BRIEF.md
# Tagged Extended-Precision Register Stack

This block holds eight 80-bit extended-precision values arranged as a rotating stack. Software-visible register number i selects the physical slot reached by adding i to a 3-bit top pointer, modulo 8. Each physical slot carries a 2-bit class tag. The tag is computed from the exponent and significand of every value written. A 16-bit status word holds the top pointer, four condition bits and the sticky exception flags. A 16-bit control word supplies the exception masks. Values are only stored, classified and moved. No arithmetic is performed.

Commands arrive on a valid/ready stream, one per accepted cycle. A command changes state at the clock edge that accepts it. Register reads produce a result on a second valid/ready stream. That result is held stable until it is taken. While a result waits with `rsp_ready` low, no further command is accepted, so back-pressure on the result stream stalls the command stream. The status, tag and control words are plain outputs that reflect every accepted command from the following cycle onward.

Pushing onto a slot that is already occupied is recorded as a stack overflow. Popping an empty top is recorded as a stack underflow. The two faults differ in the value written to condition bit C1. A packed-integer write reaches a physical slot directly and marks every slot valid.

Top module: `xstk_top`

## Requirements
- R1: After reset the tag word is 0xFFFF, the status word is 0x0000, the control word is 0x037F and `rsp_valid` is low.
- R2: Command codes on `cmd_op` are: 0 push, 1 pop, 2 read, 3 write, 4 free, 5 top+1, 6 top-1, 7 packed write, 8 load control word, 9 unordered. Other codes change nothing. A read of register i (`cmd_idx`) returns the value and tag of physical slot (TOP+i) mod 8 on `rsp_data` and `rsp_tag` with `rsp_valid` high, starting the cycle after acceptance.
- R3: A push targets slot (TOP-1) mod 8. If that slot's tag is empty, `cmd_data` is stored there and TOP becomes that slot. Otherwise it is an overflow: C1 (status bit 9), stack fault (bit 6) and invalid (bit 0) are set, and TOP and the slot stay unchanged.
- R4: A pop whose ST(0) tag is empty is an underflow. It clears C1, sets stack fault and invalid, and leaves TOP unchanged. Any other pop sets the ST(0) tag to empty and advances TOP by one modulo 8.
- R5: Tags are 00 valid, 01 zero, 10 special, 11 empty, and slot k occupies tag-word bits 2k+1:2k. A written value is classified from its exponent (bits 78:64) and significand (bits 63:0). Exponent 0 with significand 0 is zero regardless of sign (bit 79). Exponent 0 with a nonzero significand is special. Exponent 0x7FFF is special. Anything else is valid.
- R6: A write stores `cmd_data` in register i and sets its tag from the value's class. A free sets register i's tag to empty and leaves its value in place.
- R7: The increment and decrement commands move TOP by one modulo 8 and change no tag.
- R8: A packed write replaces bits 63:0 of physical slot `cmd_idx`, keeps bits 79:64, and sets the whole tag word to 0x0000.
- R9: The unordered command sets C0 (bit 8), C2 (bit 10) and C3 (bit 14) to 1.
- R10: Load control word copies `cmd_data[15:0]` into the control word. Status bit 7 is 1 exactly when some flag in status bits 5:0 is set and its control-word mask bit in 5:0 is 0.
- R11: `cmd_ready` is high when `rsp_valid` is low or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_tag` hold.
- R12: TOP occupies status bits 13:11, and the busy bit 15 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_op | input | 4 | Command code |
| cmd_idx | input | 3 | Register number, or physical slot for a packed write |
| cmd_data | input | 80 | Value to store, packed data or control word |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 80 | Value read |
| rsp_tag | output | 2 | Tag of the slot read |
| status_word | output | 16 | Condition bits, TOP, flags |
| tag_word | output | 16 | All eight slot tags |
| ctrl_word | output | 16 | Exception masks and other control bits |

## Verification
The stack is filled with normal values, positive and negative zero, a denormal, an infinity and a NaN. These show whether each exponent/significand combination lands on its own tag, and whether reads reach the slot named relative to TOP rather than an absolute one. Pops are run past the occupied region, and pushes are run into a full stack. This separates the two fault polarities of C1 and confirms that TOP and the stored value are left alone on a fault. Decrements and increments cross the 0/7 boundary to expose any missing modulo wrap. Reads issued while the result stream is back-pressured show that the held result does not change and that the next command waits.

// File: rtl/xstk_pkg.sv
package xstk_pkg;

  typedef enum logic [1:0] {
    TG_VALID = 2'b00,
    TG_ZERO  = 2'b01,
    TG_SPEC  = 2'b10,
    TG_EMPTY = 2'b11
  } tag_e;

  typedef enum logic [3:0] {
    OP_PUSH  = 4'd0,
    OP_POP   = 4'd1,
    OP_READ  = 4'd2,
    OP_WRITE = 4'd3,
    OP_FREE  = 4'd4,
    OP_INC   = 4'd5,
    OP_DEC   = 4'd6,
    OP_PKWR  = 4'd7,
    OP_LDCW  = 4'd8,
    OP_UNORD = 4'd9
  } op_e;

  localparam logic [15:0] CW_RESET = 16'h037F;

endpackage

// File: rtl/xstk_classify.sv
module xstk_classify
  import xstk_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output tag_e             tag_o
);

  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic exp_zero, exp_full, sig_zero;

  assign exp_zero = (exp_i == '0);
  assign exp_full = (exp_i == EXP_MAX);
  assign sig_zero = (sig_i == '0);

  always_comb begin
    if (exp_zero && sig_zero)      tag_o = TG_ZERO;
    else if (exp_zero || exp_full) tag_o = TG_SPEC;
    else                           tag_o = TG_VALID;
  end

endmodule

// File: rtl/xstk_regfile.sv
module xstk_regfile
  import xstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int VAL_W = 80,
  parameter int PK_W  = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PTR_W-1:0]     wr_addr,
  input  logic [VAL_W-1:0]     wr_data,
  input  logic                 pk_en,
  input  logic [PTR_W-1:0]     pk_addr,
  input  logic [PK_W-1:0]      pk_data,
  input  logic                 tg_en,
  input  logic [PTR_W-1:0]     tg_addr,
  input  tag_e                 tg_val,
  input  logic                 tg_all_valid,
  input  logic [PTR_W-1:0]     rd_addr,
  output logic [VAL_W-1:0]     rd_data,
  output logic [2*DEPTH-1:0]   tag_word
);

  logic [VAL_W-1:0] slot_val [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [VAL_W-1:0] val_q;
    tag_e             tag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (wr_en && wr_addr == PTR_W'(e)) begin
        val_q <= wr_data;
      end else if (pk_en && pk_addr == PTR_W'(e)) begin
        val_q[PK_W-1:0] <= pk_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= TG_EMPTY;
      end else if (tg_all_valid) begin
        tag_q <= TG_VALID;
      end else if (tg_en && tg_addr == PTR_W'(e)) begin
        tag_q <= tg_val;
      end
    end

    assign slot_val[e]       = val_q;
    assign tag_word[2*e +: 2] = tag_q;
  end

  assign rd_data = slot_val[rd_addr];

endmodule

// File: rtl/xstk_status.sv
module xstk_status #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             top_we,
  input  logic [PTR_W-1:0] top_nxt,
  input  logic             ovf,
  input  logic             unf,
  input  logic             unord,
  input  logic             cw_we,
  input  logic [15:0]      cw_in,
  output logic [PTR_W-1:0] top,
  output logic [15:0]      sw,
  output logic [15:0]      cw
);

  logic [5:0]       flg_q;
  logic             sf_q, c0_q, c1_q, c2_q, c3_q;
  logic [PTR_W-1:0] top_q;
  logic [15:0]      cw_q;
  logic             summary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      sf_q  <= 1'b0;
      c0_q  <= 1'b0;
      c1_q  <= 1'b0;
      c2_q  <= 1'b0;
      c3_q  <= 1'b0;
      top_q <= '0;
      cw_q  <= xstk_pkg::CW_RESET;
    end else begin
      if (top_we) top_q <= top_nxt;
      if (cw_we)  cw_q  <= cw_in;
      if (ovf || unf) begin
        sf_q     <= 1'b1;
        flg_q[0] <= 1'b1;
        c1_q     <= ovf;
      end
      if (unord) begin
        c0_q <= 1'b1;
        c2_q <= 1'b1;
        c3_q <= 1'b1;
      end
    end
  end

  assign summary = |(flg_q & ~cw_q[5:0]);
  assign top     = top_q;
  assign cw      = cw_q;
  assign sw      = {1'b0, c3_q, top_q, c2_q, c1_q, c0_q, summary, sf_q, flg_q};

endmodule

// File: rtl/xstk_top.sv
module xstk_top
  import xstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  parameter int PK_W  = 64,
  localparam int VAL_W = 1 + EXP_W + SIG_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [PTR_W-1:0]   cmd_idx,
  input  logic [VAL_W-1:0]   cmd_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [VAL_W-1:0]   rsp_data,
  output logic [1:0]         rsp_tag,
  output logic [15:0]        status_word,
  output logic [2*DEPTH-1:0] tag_word,
  output logic [15:0]        ctrl_word
);

  logic             accept;
  op_e              op;
  logic [PTR_W-1:0] top, st_addr, below_top, above_top;
  tag_e             new_tag, rd_tag, below_tag, top_tag;
  logic [VAL_W-1:0] rd_data;

  logic             wr_en, pk_en, tg_en, tg_all, top_we, ovf, unf, unord, cw_we;
  logic [PTR_W-1:0] wr_addr, tg_addr, top_nxt;
  tag_e             tg_val;

  assign accept    = cmd_valid && cmd_ready;
  assign op        = op_e'(cmd_op);
  assign st_addr   = top + cmd_idx;
  assign below_top = top - PTR_W'(1);
  assign above_top = top + PTR_W'(1);
  assign rd_tag    = tag_e'(tag_word[{st_addr, 1'b0} +: 2]);
  assign below_tag = tag_e'(tag_word[{below_top, 1'b0} +: 2]);
  assign top_tag   = tag_e'(tag_word[{top, 1'b0} +: 2]);

  xstk_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
    .exp_i (cmd_data[SIG_W +: EXP_W]),
    .sig_i (cmd_data[SIG_W-1:0]),
    .tag_o (new_tag)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = st_addr;
    pk_en   = 1'b0;
    tg_en   = 1'b0;
    tg_addr = st_addr;
    tg_val  = new_tag;
    tg_all  = 1'b0;
    top_we  = 1'b0;
    top_nxt = top;
    ovf     = 1'b0;
    unf     = 1'b0;
    unord   = 1'b0;
    cw_we   = 1'b0;
    if (accept) begin
      unique case (op)
        OP_PUSH: begin
          if (below_tag == TG_EMPTY) begin
            wr_en   = 1'b1;
            wr_addr = below_top;
            tg_en   = 1'b1;
            tg_addr = below_top;
            top_we  = 1'b1;
            top_nxt = below_top;
          end else begin
            ovf = 1'b1;
          end
        end
        OP_POP: begin
          if (top_tag == TG_EMPTY) begin
            unf = 1'b1;
          end else begin
            tg_en   = 1'b1;
            tg_addr = top;
            tg_val  = TG_EMPTY;
            top_we  = 1'b1;
            top_nxt = above_top;
          end
        end
        OP_WRITE: begin
          wr_en = 1'b1;
          tg_en = 1'b1;
        end
        OP_FREE: begin
          tg_en  = 1'b1;
          tg_val = TG_EMPTY;
        end
        OP_INC: begin
          top_we  = 1'b1;
          top_nxt = above_top;
        end
        OP_DEC: begin
          top_we  = 1'b1;
          top_nxt = below_top;
        end
        OP_PKWR: begin
          pk_en  = 1'b1;
          tg_all = 1'b1;
        end
        OP_LDCW:  cw_we = 1'b1;
        OP_UNORD: unord = 1'b1;
        default: ;
      endcase
    end
  end

  xstk_regfile #(.DEPTH(DEPTH), .VAL_W(VAL_W), .PK_W(PK_W), .PTR_W(PTR_W)) u_rf (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (cmd_data),
    .pk_en        (pk_en),
    .pk_addr      (cmd_idx),
    .pk_data      (cmd_data[PK_W-1:0]),
    .tg_en        (tg_en),
    .tg_addr      (tg_addr),
    .tg_val       (tg_val),
    .tg_all_valid (tg_all),
    .rd_addr      (st_addr),
    .rd_data      (rd_data),
    .tag_word     (tag_word)
  );

  xstk_status #(.PTR_W(PTR_W)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .top_we  (top_we),
    .top_nxt (top_nxt),
    .ovf     (ovf),
    .unf     (unf),
    .unord   (unord),
    .cw_we   (cw_we),
    .cw_in   (cmd_data[15:0]),
    .top     (top),
    .sw      (status_word),
    .cw      (ctrl_word)
  );

  assign cmd_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= 2'b00;
    end else if (accept && op == OP_READ) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_data;
      rsp_tag   <= rd_tag;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/xstk_chk.sv
module xstk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [3:0]  cmd_op,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [79:0] rsp_data,
  input logic [15:0] status_word,
  input logic [15:0] tag_word
);

  logic       acc;
  logic [2:0] tp, tp_dn;
  logic [1:0] tg_below, tg_top;

  assign acc      = cmd_valid && cmd_ready;
  assign tp       = status_word[13:11];
  assign tp_dn    = tp - 3'd1;
  assign tg_below = tag_word[{tp_dn, 1'b0} +: 2];
  assign tg_top   = tag_word[{tp, 1'b0} +: 2];

  p_push_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd0 && tg_below == 2'b11 |=> status_word[13:11] == $past(tp_dn));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd0 && tg_below != 2'b11 |=>
      status_word[9] && status_word[6] && status_word[0] && status_word[13:11] == $past(tp));

  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd1 && tg_top == 2'b11 |=>
      !status_word[9] && status_word[6] && status_word[0] && status_word[13:11] == $past(tp));

  p_pk_tags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd7 |=> tag_word == 16'h0000);

  p_unord_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd9 |=> status_word[8] && status_word[10] && status_word[14]);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[15]);

endmodule

bind xstk_top xstk_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .status_word (status_word),
  .tag_word    (tag_word)
);

// File: tb/xstk_top_tb.sv
module xstk_top_tb;

  localparam logic [3:0] C_PUSH = 4'd0, C_POP = 4'd1, C_READ = 4'd2, C_WRITE = 4'd3,
                         C_FREE = 4'd4, C_INC = 4'd5, C_DEC = 4'd6, C_PKWR = 4'd7,
                         C_LDCW = 4'd8, C_UNORD = 4'd9;

  localparam logic [79:0] V_ONE  = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_TWO  = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_NZRO = {1'b1, 15'h0000, 64'h0};
  localparam logic [79:0] V_PZRO = 80'h0;
  localparam logic [79:0] V_DEN  = {1'b0, 15'h0000, 64'h1};
  localparam logic [79:0] V_INF  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] V_NAN  = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] cmd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [79:0] rsp_data;
  logic [1:0]  rsp_tag;
  logic [15:0] status_word, tag_word, ctrl_word;

  always #2 clk = ~clk;

  xstk_top u_dut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_op (cmd_op),
    .cmd_idx (cmd_idx), .cmd_data (cmd_data),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data), .rsp_tag (rsp_tag),
    .status_word (status_word), .tag_word (tag_word), .ctrl_word (ctrl_word)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [79:0] m_val [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top = '0;
  logic [5:0]  m_flg = '0;
  logic        m_sf = 0, m_c0 = 0, m_c1 = 0, m_c2 = 0, m_c3 = 0;
  logic [15:0] m_cw = 16'h037F;
  logic [81:0] exp_q [$];

  task automatic chk(input string req, input logic [81:0] act, input logic [81:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [1:0] cls(input logic [79:0] v);
    if (v[78:64] == 15'h0 && v[63:0] == 64'h0) return 2'b01;
    if (v[78:64] == 15'h0 || v[78:64] == 15'h7FFF) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [15:0] m_sw();
    logic es;
    es = |(m_flg & ~m_cw[5:0]);
    return {1'b0, m_c3, m_top, m_c2, m_c1, m_c0, es, m_sf, m_flg};
  endfunction

  function automatic logic [15:0] m_tw();
    logic [15:0] t;
    for (int k = 0; k < 8; k++) t[2*k +: 2] = m_tag[k];
    return t;
  endfunction

  task automatic send(input logic [3:0] op, input logic [2:0] idx, input logic [79:0] d,
                      input string req);
    logic [2:0] a;
    @(negedge clk);
    cmd_op = op; cmd_idx = idx; cmd_data = d; cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    case (op)
      C_PUSH: begin
        a = m_top - 3'd1;
        if (m_tag[a] != 2'b11) begin m_c1 = 1; m_sf = 1; m_flg[0] = 1; end
        else begin m_val[a] = d; m_tag[a] = cls(d); m_top = a; end
      end
      C_POP: begin
        if (m_tag[m_top] == 2'b11) begin m_c1 = 0; m_sf = 1; m_flg[0] = 1; end
        else begin m_tag[m_top] = 2'b11; m_top = m_top + 3'd1; end
      end
      C_READ: begin
        a = m_top + idx;
        exp_q.push_back({m_tag[a], m_val[a]});
      end
      C_WRITE: begin a = m_top + idx; m_val[a] = d; m_tag[a] = cls(d); end
      C_FREE:  begin a = m_top + idx; m_tag[a] = 2'b11; end
      C_INC:   m_top = m_top + 3'd1;
      C_DEC:   m_top = m_top - 3'd1;
      C_PKWR:  begin m_val[idx][63:0] = d[63:0]; for (int k = 0; k < 8; k++) m_tag[k] = 2'b00; end
      C_LDCW:  m_cw = d[15:0];
      C_UNORD: begin m_c0 = 1; m_c2 = 1; m_c3 = 1; end
      default: ;
    endcase
    chk({req, " status"}, {66'b0, status_word}, {66'b0, m_sw()});
    chk({req, " tags"},   {66'b0, tag_word},    {66'b0, m_tw()});
    chk({req, " ctrl"},   {66'b0, ctrl_word},   {66'b0, m_cw});
  endtask

  // scoreboard monitor for the result stream
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R2 unexpected result actual=%h expected=none", rsp_data);
      end else if (rsp_ready) begin
        chk("R2 read result", {rsp_tag, rsp_data}, exp_q.pop_front());
      end else begin
        chk("R11 held result", {rsp_tag, rsp_data}, exp_q[0]);
        chk("R11 ready low", {81'b0, cmd_ready}, 82'b0);
      end
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m_val[k] = '0; m_tag[k] = 2'b11; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tag word",    {66'b0, tag_word},    {66'b0, 16'hFFFF});
    chk("R1 status word", {66'b0, status_word}, 82'h0);
    chk("R1 ctrl word",   {66'b0, ctrl_word},   {66'b0, 16'h037F});
    chk("R1 rsp_valid",   {81'b0, rsp_valid},   82'h0);
    rst_n = 1'b1;

    // R3 R5: pushes of every value class
    send(C_PUSH, 0, V_ONE,  "R3 push normal");
    send(C_READ, 0, '0,     "R2 read st0");
    send(C_PUSH, 0, V_NZRO, "R5 push -0");
    send(C_PUSH, 0, V_DEN,  "R5 push denormal");
    send(C_PUSH, 0, V_INF,  "R5 push inf");
    send(C_PUSH, 0, V_NAN,  "R5 push nan");
    send(C_READ, 3, '0,     "R2 read st3");
    send(C_READ, 1, '0,     "R2 read st1");

    // R6 write and free
    send(C_WRITE, 4, V_TWO,  "R6 write st4");
    send(C_WRITE, 2, V_PZRO, "R6 write st2 zero");
    send(C_FREE,  1, '0,     "R6 free st1");
    send(C_READ,  1, '0,     "R6 read freed");
    send(C_READ,  4, '0,     "R6 read written");

    // R4 pops and underflow
    send(C_POP, 0, '0, "R4 pop ok");
    send(C_POP, 0, '0, "R4 pop empty underflow");
    send(C_INC, 0, '0, "R7 inc past hole");
    for (int k = 0; k < 3; k++) send(C_POP, 0, '0, "R4 pop ok");
    send(C_POP, 0, '0, "R4 underflow all empty");

    // R7 wrap both ways
    send(C_DEC, 0, '0, "R7 dec wrap");
    send(C_DEC, 0, '0, "R7 dec");
    send(C_INC, 0, '0, "R7 inc");
    send(C_INC, 0, '0, "R7 inc wrap");

    // R3 overflow after filling
    for (int k = 0; k < 8; k++)
      send(C_PUSH, 0, {1'b0, 15'h3FFF + 15'(k), 64'h8000_0000_0000_0000 | 64'(k)}, "R3 fill");
    send(C_PUSH, 0, V_INF, "R3 push overflow");
    send(C_READ, 0, '0,    "R3 st0 kept");

    // R10 masks and summary
    send(C_LDCW, 0, 80'h0360, "R10 unmask invalid");
    send(C_LDCW, 0, 80'h037F, "R10 remask");

    // R9
    send(C_UNORD, 0, '0, "R9 unordered");

    // R8 packed write
    send(C_POP,  0, '0, "R4 pop before pack");
    send(C_PKWR, 2, 80'h0123_4567_89AB_CDEF, "R8 packed write");
    send(C_READ, 1, '0, "R8 read packed slot");
    send(C_READ, 7, '0, "R8 read other slot");
    send(4'd12, 0, V_INF, "R2 unused code");

    // R11 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(C_READ, 0, '0, "R11 first read");
    fork
      send(C_READ, 1, '0, "R11 stalled read");
      begin repeat (4) @(posedge clk); #1 rsp_ready = 1'b1; end
    join

    repeat (5) @(posedge clk);
    chk("R2 all results seen", {50'b0, 32'(exp_q.size())}, 82'h0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule